// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Write Enables

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on their own clocks. The two clocks may be unrelated or may be the same clock. Words enter on the rising write clock edge. They leave through a registered output on the rising read clock edge, and a three-state output stage drives that register onto the data bus.

One input has two meanings. Its level is sampled while reset is held, and the sampled value selects the mode until the next reset. When the pin is high during reset, it becomes a second write enable that must also be asserted for a write, which lets several buffers share one data bus to form a deeper buffer. When the pin is low during reset, it is treated as the load strobe of an external offset register file and has no effect on writes. Two offset values arrive on ports and set the thresholds of the almost-full and almost-empty flags.

Each side computes its flags from its own pointer and a two-stage synchronised Gray-coded copy of the other side's pointer. A flag can therefore release late, but it never asserts late.

Top module: `dcfifo_cfgen`

## Requirements
- R1: While `rst` is high, each clock domain returns its pointer to location zero and clears the output register to zero. After reset, `full_n` and `afull_n` read 1, `empty_n` and `aempty_n` read 0, and `dout` reads 0 with `oe_n` low.
- R2: Words are returned in the order they were accepted. A word is accepted on a rising `wclk` edge when the write conditions of the current mode hold and `full_n` is 1.
- R3: If `wen2_ld` was 1 during reset (second-enable mode), a write needs both `wen1_n`=0 and `wen2_ld`=1. With `wen2_ld`=0 nothing is stored.
- R4: If `wen2_ld` was 0 during reset (offset-strobe mode), `wen1_n`=0 alone causes a write and the level of `wen2_ld` does not matter.
- R5: A read takes place on a rising `rclk` edge only when `ren1_n` and `ren2_n` are both 0. Otherwise the output register keeps its value.
- R6: `full_n` is 0 when the buffer holds DEPTH words. Write enables have no effect while it is 0, and it returns to 1 a few write clocks after a read.
- R7: `empty_n` is 0 when no word is stored. Read enables have no effect while it is 0, and it returns to 1 a few read clocks after a write.
- R8: Once traffic has settled, `afull_n` is 0 exactly when the free space (DEPTH minus the stored count) is at most `full_ofs`. It is synchronous to `wclk`.
- R9: Once traffic has settled, `aempty_n` is 0 exactly when the stored count is at most `empty_ofs`. It is synchronous to `rclk`.
- R10: While `oe_n` is 1, every bit of `dout` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| din | input | WIDTH | Write data |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Mode select during reset; after reset, the second write enable (active high) or the offset load strobe |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low; high floats `dout` |
| empty_ofs | input | log2(DEPTH) | Almost-empty threshold in words |
| full_ofs | input | log2(DEPTH) | Almost-full threshold in free words |
| dout | output | WIDTH | Three-state read data |
| full_n | output | 1 | Full flag, active low, write clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write clock domain |
| empty_n | output | 1 | Empty flag, active low, read clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock domain |

## Verification
The hardest checks are the exact thresholds of the programmable flags. While both sides are active, these flags may lag the true fill level, because each side sees the other's pointer only through the synchronisers. The stimulus therefore stops all traffic and waits several cycles of both clocks before comparing a flag with the bench's own count. It then changes the fill level one word at a time, or changes an offset, so that the flag is seen on both sides of its boundary. A write attempted with the second enable low in second-enable mode is observed through `empty_n` after settling, and through the data order when the buffer is drained.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    // widest pointer the conversion helpers support
    localparam int PTR_MAX_W = 16;
    typedef logic [PTR_MAX_W-1:0] ptr_word_t;

    // meaning of the dual-purpose pin, latched while reset is high
    typedef enum logic {
        MODE_OFS_STROBE = 1'b0,
        MODE_DUAL_WEN   = 1'b1
    } wr_mode_e;

    // synchronised flag pair produced by each side
    typedef struct packed {
        logic hard_n;   // full or empty, active low
        logic soft_n;   // almost-full or almost-empty, active low
    } flag_pair_t;

    function automatic ptr_word_t bin2gray(input ptr_word_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_word_t gray2bin(input ptr_word_t g);
        ptr_word_t b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
    import fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              wen1_n,
    input  logic              wen2_ld,
    input  logic [PTR_W-1:0]  rgray_sync,
    input  logic [ADDR_W-1:0] full_ofs,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray,
    output flag_pair_t        flags
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    wr_mode_e         mode_q;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_nxt;
    logic [PTR_W-1:0] rbin_seen;
    logic [PTR_W-1:0] level;
    logic [PTR_W-1:0] space;
    logic             is_full;
    logic             enabled;

    assign rbin_seen = PTR_W'(gray2bin(ptr_word_t'(rgray_sync)));
    assign level     = wbin - rbin_seen;
    assign space     = DEPTH_P - level;
    assign is_full   = (level == DEPTH_P);

    always_comb begin
        if (mode_q == MODE_DUAL_WEN) begin
            enabled = !wen1_n && wen2_ld;
        end else begin
            enabled = !wen1_n;
        end
    end

    assign we       = enabled && !is_full;
    assign wbin_nxt = wbin + PTR_W'(we);
    assign waddr    = wbin[ADDR_W-1:0];

    always_ff @(posedge wclk) begin
        if (rst) begin
            mode_q <= wen2_ld ? MODE_DUAL_WEN : MODE_OFS_STROBE;
            wbin   <= '0;
            wgray  <= '0;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= PTR_W'(bin2gray(ptr_word_t'(wbin_nxt)));
        end
    end

    assign flags.hard_n = !is_full;
    assign flags.soft_n = !(space <= {1'b0, full_ofs});

    a_r6_hold_when_full: assert property (@(posedge wclk) disable iff (rst)
        (!flags.hard_n) |=> $stable(wbin));

    a_r6_level_bound: assert property (@(posedge wclk) disable iff (rst)
        level <= DEPTH_P);

    a_r3_second_enable: assert property (@(posedge wclk) disable iff (rst)
        (mode_q == MODE_DUAL_WEN && !wen2_ld) |=> $stable(wbin));

    a_r2_gray_single_step: assert property (@(posedge wclk) disable iff (rst)
        1'b1 |=> $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [ADDR_W-1:0] empty_ofs,
    input  logic [WIDTH-1:0]  rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [WIDTH-1:0]  dout_q,
    output flag_pair_t        flags
);
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] rbin_nxt;
    logic [PTR_W-1:0] wbin_seen;
    logic [PTR_W-1:0] level;
    logic             is_empty;
    logic             take;

    assign wbin_seen = PTR_W'(gray2bin(ptr_word_t'(wgray_sync)));
    assign level     = wbin_seen - rbin;
    assign is_empty  = (level == '0);
    assign take      = !ren1_n && !ren2_n && !is_empty;
    assign rbin_nxt  = rbin + PTR_W'(take);
    assign raddr     = rbin[ADDR_W-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            dout_q <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= PTR_W'(bin2gray(ptr_word_t'(rbin_nxt)));
            if (take) begin
                dout_q <= rdata;
            end
        end
    end

    assign flags.hard_n = !is_empty;
    assign flags.soft_n = !(level <= {1'b0, empty_ofs});

    a_r7_hold_when_empty: assert property (@(posedge rclk) disable iff (rst)
        (!flags.hard_n) |=> ($stable(rbin) && $stable(dout_q)));

    a_r5_both_enables: assert property (@(posedge rclk) disable iff (rst)
        (ren1_n || ren2_n) |=> ($stable(dout_q) && $stable(rbin)));

    a_r2_gray_single_step_rd: assert property (@(posedge rclk) disable iff (rst)
        1'b1 |=> $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/dcfifo_cfgen.sv
module dcfifo_cfgen
    import fifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  din,
    input  logic              wen1_n,
    input  logic              wen2_ld,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] empty_ofs,
    input  logic [ADDR_W-1:0] full_ofs,
    output logic [WIDTH-1:0]  dout,
    output logic              full_n,
    output logic              afull_n,
    output logic              empty_n,
    output logic              aempty_n
);
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [WIDTH-1:0]  rdata;
    logic [WIDTH-1:0]  dout_q;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_sync;
    logic [PTR_W-1:0]  rgray_sync;
    flag_pair_t        wflags;
    flag_pair_t        rflags;

    fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    fifo_sync2 #(.W(PTR_W)) u_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rgray),
        .q   (rgray_sync)
    );

    fifo_sync2 #(.W(PTR_W)) u_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wgray),
        .q   (wgray_sync)
    );

    fifo_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wclk       (wclk),
        .rst        (rst),
        .wen1_n     (wen1_n),
        .wen2_ld    (wen2_ld),
        .rgray_sync (rgray_sync),
        .full_ofs   (full_ofs),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .flags      (wflags)
    );

    fifo_rd_side #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
        .rclk       (rclk),
        .rst        (rst),
        .ren1_n     (ren1_n),
        .ren2_n     (ren2_n),
        .wgray_sync (wgray_sync),
        .empty_ofs  (empty_ofs),
        .rdata      (rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .dout_q     (dout_q),
        .flags      (rflags)
    );

    assign full_n   = wflags.hard_n;
    assign afull_n  = wflags.soft_n;
    assign empty_n  = rflags.hard_n;
    assign aempty_n = rflags.soft_n;
    assign dout     = oe_n ? {WIDTH{1'bz}} : dout_q;
endmodule

// File: tb/tb_dcfifo_cfgen.sv
module tb_dcfifo_cfgen;
    localparam int W = 9;
    localparam int D = 16;
    localparam int A = $clog2(D);

    logic         wclk = 1'b0;
    logic         rclk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         wen1_n = 1'b1;
    logic         wen2_ld = 1'b1;
    logic         ren1_n = 1'b1;
    logic         ren2_n = 1'b1;
    logic         oe_n = 1'b0;
    logic [A-1:0] empty_ofs = '0;
    logic [A-1:0] full_ofs = '0;
    wire  [W-1:0] dout;
    wire          full_n, afull_n, empty_n, aempty_n;

    int           n_checks = 0;
    int           n_fail = 0;
    bit           ofs_mode = 1'b0;
    logic [W-1:0] last_out = '0;
    logic [W-1:0] sb [$];

    always #10 wclk = ~wclk;          // 50 MHz write clock
    initial begin
        #3;
        forever #13 rclk = ~rclk;     // unrelated read clock
    end

    dcfifo_cfgen #(.WIDTH(W), .DEPTH(D)) dut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .din(din),
        .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .oe_n(oe_n), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .dout(dout), .full_n(full_n), .afull_n(afull_n),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic do_reset(input logic pin);
        wen2_ld = pin;
        wen1_n  = 1'b1;
        ren1_n  = 1'b1;
        ren2_n  = 1'b1;
        rst     = 1'b1;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst = 1'b0;
        sb.delete();
        last_out = '0;
        ofs_mode = !pin;
        settle();
    endtask

    // driver: one write-clock cycle, pushes the word if it is predicted to be stored
    task automatic wr(input logic [W-1:0] d, input logic e1n, input logic e2);
        @(negedge wclk);
        din     = d;
        wen1_n  = e1n;
        wen2_ld = e2;
        if (!e1n && (ofs_mode || e2) && full_n) sb.push_back(d);
    endtask

    task automatic wr_idle();
        @(negedge wclk);
        wen1_n = 1'b1;
    endtask

    // monitor: rot=1 rotates the read enables so only every third cycle reads
    task automatic rd(input int n, input bit rot, input string hold_req);
        bit pend = 1'b0;
        logic [W-1:0] e;
        for (int i = 0; i <= n; i++) begin
            @(negedge rclk);
            if (i > 0) begin
                if (pend) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R2 underflow", 0, 0);
                    end else begin
                        e = sb.pop_front();
                        chk(dout === e, "R2 order", 32'(dout), 32'(e));
                        last_out = e;
                    end
                end else begin
                    chk(dout === last_out, hold_req, 32'(dout), 32'(last_out));
                end
            end
            if (i < n) begin
                if (rot) begin
                    ren1_n = (i % 3 == 0);
                    ren2_n = (i % 3 == 1);
                end else begin
                    ren1_n = 1'b0;
                    ren2_n = 1'b0;
                end
                pend = empty_n && !ren1_n && !ren2_n;
            end else begin
                ren1_n = 1'b1;
                ren2_n = 1'b1;
            end
        end
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // second-enable mode
        do_reset(1'b1);
        chk(full_n === 1'b1, "R1 full_n", 32'(full_n), 1);
        chk(afull_n === 1'b1, "R1 afull_n", 32'(afull_n), 1);
        chk(empty_n === 1'b0, "R1 empty_n", 32'(empty_n), 0);
        chk(aempty_n === 1'b0, "R1 aempty_n", 32'(aempty_n), 0);
        chk(dout === '0, "R1 dout", 32'(dout), 0);

        // R3: second enable low stores nothing
        for (int i = 0; i < 3; i++) wr(9'h0F0 + 9'(i), 1'b0, 1'b0);
        wr_idle();
        settle();
        chk(empty_n === 1'b0, "R3 blocked write", 32'(empty_n), 0);

        // R2/R3: five words, interleaved with blocked attempts
        for (int i = 0; i < 5; i++) begin
            wr(9'h1A0 + 9'(i), 1'b0, 1'b1);
            wr(9'h055, 1'b0, 1'b0);
        end
        wr_idle();
        settle();
        chk(empty_n === 1'b1, "R7 release", 32'(empty_n), 1);
        empty_ofs = 4'd5;
        @(negedge rclk);
        chk(aempty_n === 1'b0, "R9 level5 ofs5", 32'(aempty_n), 0);
        empty_ofs = 4'd4;
        @(negedge rclk);
        chk(aempty_n === 1'b1, "R9 level5 ofs4", 32'(aempty_n), 1);

        // R5: rotated enables, then drain
        rd(9, 1'b1, "R5 hold");
        rd(4, 1'b0, "R7 hold empty");
        settle();
        chk(empty_n === 1'b0, "R7 empty", 32'(empty_n), 0);
        chk(sb.size() == 0, "R2 drained", 32'(sb.size()), 0);
        rd(4, 1'b0, "R7 read ignored");

        // R6/R8: overfill
        full_ofs = 4'd2;
        for (int i = 0; i < D + 4; i++) wr(9'h100 + 9'(i * 7), 1'b0, 1'b1);
        wr_idle();
        chk(sb.size() == D, "R6 accepted count", 32'(sb.size()), D);
        settle();
        chk(full_n === 1'b0, "R6 full", 32'(full_n), 0);
        chk(afull_n === 1'b0, "R8 free0", 32'(afull_n), 0);
        rd(2, 1'b0, "R5 hold");
        settle();
        chk(full_n === 1'b1, "R6 release", 32'(full_n), 1);
        chk(afull_n === 1'b0, "R8 free2 ofs2", 32'(afull_n), 0);
        rd(1, 1'b0, "R5 hold");
        settle();
        chk(afull_n === 1'b1, "R8 free3 ofs2", 32'(afull_n), 1);

        // R10: output float
        @(negedge rclk);
        oe_n = 1'b1;
        #1;
        chk(dout === {W{1'bz}}, "R10 float", 32'(dout), 32'h1ff);
        oe_n = 1'b0;
        #1;
        chk(dout === last_out, "R10 drive", 32'(dout), 32'(last_out));
        rd(D, 1'b0, "R7 hold empty");
        chk(sb.size() == 0, "R2 drained full", 32'(sb.size()), 0);

        // offset-strobe mode
        do_reset(1'b0);
        chk(dout === '0, "R1 dout", 32'(dout), 0);
        for (int i = 0; i < 4; i++) wr(9'h0C3 ^ 9'(i * 5), 1'b0, 1'b0);
        wr(9'h1FF, 1'b1, 1'b1);
        wr(9'h011, 1'b0, 1'b1);
        wr_idle();
        settle();
        chk(empty_n === 1'b1, "R4 write with pin low", 32'(empty_n), 1);
        chk(sb.size() == 5, "R4 accepted count", 32'(sb.size()), 5);
        rd(7, 1'b1, "R5 hold");
        rd(3, 1'b0, "R7 hold empty");
        chk(sb.size() == 0, "R4 drained", 32'(sb.size()), 0);

        finish_run();
    end
endmodule